// File: doc/BRIEF.md
# Floating-Point Condition Flags and Predicate Unit

This block keeps the four condition flags of an extended-precision floating-point unit. The flags are negative, zero, infinity and not-a-number, and they are held inside a 32-bit status word. When the datapath finishes an operation it raises an update strobe. The strobe carries the 80-bit result: a 16-bit sign/exponent word and a 64-bit mantissa with an explicit integer bit. The block classifies that value and rewrites the four flag bits in one cycle. The remaining status bits are left as they were.

Branch and set-on-condition logic asks for an evaluation by raising a request with a 6-bit condition selector. The low four bits pick one of sixteen predicates. These predicates are aware of IEEE ordering: the not-a-number flag decides whether each ordered or unordered comparison holds. Bit 4 of the selector is a don't-care. Bit 5 marks a selector that is not legal.

A small control machine has the states IDLE, RESULT and FAULT. It answers each request one cycle later. The answer is a true/false verdict for branching plus a byte of all ones or all zeros for set-on-condition use. An illegal selector gives a one-cycle illegal pulse instead of a verdict. Transitions are as follows:
- IDLE, RESULT or FAULT moves to RESULT on a legal request.
- IDLE, RESULT or FAULT moves to FAULT on an illegal request.
- IDLE, RESULT or FAULT moves to IDLE when no request is present.

Top module: `fpcc_unit`

## Requirements
- R1: The flags occupy status bits 27 (negative), 26 (zero), 25 (infinity) and 24 (not-a-number). An update clears all four and sets them from the new value one cycle after the strobe. Every other status bit keeps its reset value, which is RESET_STATUS (default 0xF0A5C35A).
- R2: The negative flag equals bit 15 of the sign/exponent word, whatever the class of the value.
- R3: The zero flag is set when exponent bits 14:0 are all zero and mantissa bits 62:0 are all zero. Mantissa bit 63 has no effect on it.
- R4: The infinity flag is set when exponent bits 14:0 are all ones and mantissa bits 62:0 are zero. Mantissa bit 63 has no effect on it.
- R5: The not-a-number flag is set when exponent bits 14:0 are all ones and mantissa bits 62:0 are nonzero.
- R6: Selector bit 4 is ignored. A selector from 0x10 to 0x1F gives the same verdict as the same selector with bit 4 cleared.
- R7: Predicate codes in selector bits 3:0, using Z, N and NaN for the flags:
  - 0: false
  - 1: Z
  - 2: not (NaN or Z or N)
  - 3: Z or not (NaN or N)
  - 4: N and not (NaN or Z)
  - 5: Z or (N and not NaN)
  - 6: not NaN and not Z
  - 7: not NaN
- R8: Predicate codes in selector bits 3:0, continued:
  - 8: NaN
  - 9: NaN or Z
  - A: NaN or not (N or Z)
  - B: NaN or Z or not N
  - C: NaN or (N and not Z)
  - D: NaN or Z or N
  - E: not Z
  - F: true
- R9: The set-on-condition byte is 0xFF when the verdict is true and 0x00 otherwise.
- R10: A selector with bit 5 set gives, one cycle later, res_valid high, illegal_sel high for one cycle, cond_true low and a byte of 0x00.
- R11: res_valid is high for exactly the cycle after each request and low otherwise. A request made in the same cycle as an update is judged on the flags held before that update.
- R12: During and right after reset the status word equals RESET_STATUS, and res_valid, cond_true, illegal_sel and the byte are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Flag update strobe |
| upd_sign_exp | input | 16 | Sign bit and 15-bit biased exponent of the result |
| upd_mantissa | input | 64 | Mantissa including explicit integer bit 63 |
| eval_req | input | 1 | Condition evaluation request |
| eval_sel | input | 6 | Condition selector |
| status_q | output | 32 | Status word holding the flags |
| res_valid | output | 1 | Evaluation answer valid |
| cond_true | output | 1 | Verdict for branch use |
| set_byte | output | 8 | All ones or all zeros for set-on-condition |
| illegal_sel | output | 1 | Pulse for an illegal selector |

## Verification
The hardest case to reach is an update and an evaluation landing in the same cycle, where the verdict must reflect the old flags and not the incoming ones. The stimulus first loads a zero value, then in one cycle strobes an infinity and asks for the zero predicate, and expects true. Hidden-bit cases also need deliberate stimulus: zero and infinity values are driven with mantissa bit 63 set, and a NaN is driven with only mantissa bit 0 set. Every selector from 0 to 63 is swept over nine value classes.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;

    // Flag bundle; order matches the status bit layout from high to low.
    typedef struct packed {
        logic neg;
        logic zero;
        logic inf;
        logic nan;
    } cc_flags_t;

    localparam int CC_FLAG_COUNT = 4;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } ctrl_state_t;

endpackage

// File: rtl/fpcc_classify.sv
module fpcc_classify
    import fpcc_pkg::*;
#(
    parameter int SE_W  = 16,
    parameter int MAN_W = 64
) (
    input  logic [SE_W-1:0]  sign_exp,
    input  logic [MAN_W-1:0] mantissa,
    output cc_flags_t        flags
);
    localparam int EXP_W  = SE_W - 1;
    localparam int FRAC_W = MAN_W - 1;

    logic [EXP_W-1:0]  exp_field;
    logic [FRAC_W-1:0] frac_field;
    logic exp_zero;
    logic exp_ones;
    logic frac_zero;

    always_comb begin
        exp_field  = sign_exp[EXP_W-1:0];
        frac_field = mantissa[FRAC_W-1:0];
        exp_zero   = (exp_field == '0);
        exp_ones   = &exp_field;
        frac_zero  = (frac_field == '0);
        flags.neg  = sign_exp[SE_W-1];
        flags.zero = exp_zero & frac_zero;
        flags.inf  = exp_ones & frac_zero;
        flags.nan  = exp_ones & ~frac_zero;
    end

    // R5
    always_comb begin
        if (flags.nan) begin
            nan_needs_ones_chk: assert (exp_ones);
        end
    end

endmodule

// File: rtl/fpcc_status.sv
module fpcc_status
    import fpcc_pkg::*;
#(
    parameter int          STAT_W       = 32,
    parameter int          FLAG_LSB     = 24,
    parameter logic [31:0] RESET_STATUS = 32'hF0A5_C35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  cc_flags_t         flags_in,
    output logic [STAT_W-1:0] stat_q,
    output cc_flags_t         flags_q
);
    localparam int FLAG_HI = FLAG_LSB + CC_FLAG_COUNT - 1;
    localparam logic [STAT_W-1:0] FLAG_MASK =
        {{(STAT_W-CC_FLAG_COUNT){1'b0}}, {CC_FLAG_COUNT{1'b1}}} << FLAG_LSB;
    localparam logic [STAT_W-1:0] INIT_VAL = RESET_STATUS[STAT_W-1:0] & ~FLAG_MASK;

    logic [STAT_W-1:0] placed;

    always_comb begin
        placed = '0;
        placed[FLAG_HI:FLAG_LSB] = flags_in;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= INIT_VAL;
        end else if (upd) begin
            stat_q <= (stat_q & ~FLAG_MASK) | placed;
        end
    end

    assign flags_q = stat_q[FLAG_HI:FLAG_LSB];

    // R1
    keep_other_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(stat_q & ~FLAG_MASK));

    // R3
    class_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({flags_q.zero, flags_q.inf, flags_q.nan}));

    // R1
    hold_without_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(stat_q));

endmodule

// File: rtl/fpcc_predicate.sv
module fpcc_predicate
    import fpcc_pkg::*;
(
    input  cc_flags_t  flags,
    input  logic [3:0] code,
    output logic       hit
);
    logic n, z, u;

    always_comb begin
        n = flags.neg;
        z = flags.zero;
        u = flags.nan;
        unique case (code)
            4'h0: hit = 1'b0;
            4'h1: hit = z;
            4'h2: hit = ~(u | z | n);
            4'h3: hit = z | ~(u | n);
            4'h4: hit = n & ~(u | z);
            4'h5: hit = z | (n & ~u);
            4'h6: hit = ~u & ~z;
            4'h7: hit = ~u;
            4'h8: hit = u;
            4'h9: hit = u | z;
            4'hA: hit = u | ~(n | z);
            4'hB: hit = u | z | ~n;
            4'hC: hit = u | (n & ~z);
            4'hD: hit = u | z | n;
            4'hE: hit = ~z;
            4'hF: hit = 1'b1;
            default: hit = 1'b0;
        endcase
    end

    // R7
    always_comb begin
        if (code == 4'h7 && flags.nan) begin
            ordered_nan_chk: assert (!hit);
        end
    end

    // R8
    always_comb begin
        if (code == 4'h8) begin
            unordered_tracks_nan_chk: assert (hit == flags.nan);
        end
    end

endmodule

// File: rtl/fpcc_ctrl.sv
module fpcc_ctrl
    import fpcc_pkg::*;
#(
    parameter int SEL_W  = 6,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic [SEL_W-1:0]  sel,
    input  logic              hit,
    output logic              res_valid,
    output logic              cond_true,
    output logic [BYTE_W-1:0] set_byte,
    output logic              illegal_sel
);
    localparam int ILL_BIT = SEL_W - 1;

    ctrl_state_t state_q, state_d;
    logic        verdict_q;

    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE, ST_RESULT, ST_FAULT: begin
                if (req) state_d = sel[ILL_BIT] ? ST_FAULT : ST_RESULT;
                else     state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            verdict_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            verdict_q <= req & ~sel[ILL_BIT] & hit;
        end
    end

    always_comb begin
        res_valid   = 1'b0;
        cond_true   = 1'b0;
        illegal_sel = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: begin
                res_valid = 1'b1;
                cond_true = verdict_q;
            end
            ST_FAULT: begin
                res_valid   = 1'b1;
                illegal_sel = 1'b1;
            end
            default: ;
        endcase
        set_byte = {BYTE_W{cond_true}};
    end

    // R10
    illegal_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && sel[ILL_BIT]) |=> (illegal_sel && !cond_true));

    // R11
    answer_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req |=> res_valid);

    // R11
    quiet_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req |=> !res_valid);

    // R10
    legal_no_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !sel[ILL_BIT]) |=> !illegal_sel);

endmodule

// File: rtl/fpcc_unit.sv
module fpcc_unit
    import fpcc_pkg::*;
#(
    parameter int          SE_W         = 16,
    parameter int          MAN_W        = 64,
    parameter int          STAT_W       = 32,
    parameter int          FLAG_LSB     = 24,
    parameter int          SEL_W        = 6,
    parameter int          BYTE_W       = 8,
    parameter logic [31:0] RESET_STATUS = 32'hF0A5_C35A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_valid,
    input  logic [SE_W-1:0]   upd_sign_exp,
    input  logic [MAN_W-1:0]  upd_mantissa,
    input  logic              eval_req,
    input  logic [SEL_W-1:0]  eval_sel,
    output logic [STAT_W-1:0] status_q,
    output logic              res_valid,
    output logic              cond_true,
    output logic [BYTE_W-1:0] set_byte,
    output logic              illegal_sel
);
    cc_flags_t new_flags;
    cc_flags_t held_flags;
    logic      pred_hit;

    fpcc_classify #(.SE_W(SE_W), .MAN_W(MAN_W)) u_classify (
        .sign_exp (upd_sign_exp),
        .mantissa (upd_mantissa),
        .flags    (new_flags)
    );

    fpcc_status #(.STAT_W(STAT_W), .FLAG_LSB(FLAG_LSB), .RESET_STATUS(RESET_STATUS)) u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd      (upd_valid),
        .flags_in (new_flags),
        .stat_q   (status_q),
        .flags_q  (held_flags)
    );

    fpcc_predicate u_predicate (
        .flags (held_flags),
        .code  (eval_sel[3:0]),
        .hit   (pred_hit)
    );

    fpcc_ctrl #(.SEL_W(SEL_W), .BYTE_W(BYTE_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .req         (eval_req),
        .sel         (eval_sel),
        .hit         (pred_hit),
        .res_valid   (res_valid),
        .cond_true   (cond_true),
        .set_byte    (set_byte),
        .illegal_sel (illegal_sel)
    );

endmodule

// File: tb/fpcc_unit_tb.sv
module fpcc_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        upd_valid = 1'b0;
    logic [15:0] upd_sign_exp = '0;
    logic [63:0] upd_mantissa = '0;
    logic        eval_req = 1'b0;
    logic [5:0]  eval_sel = '0;
    logic [31:0] status_q;
    logic        res_valid, cond_true, illegal_sel;
    logic [7:0]  set_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    localparam logic [31:0] RST_VAL = 32'hF0A5_C35A;

    fpcc_unit u_dut (.*);

    always #10 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    function automatic logic [3:0] ref_flags(input logic [15:0] se, input logic [63:0] m);
        logic ez = (se[14:0] == 15'h0);
        logic eo = (se[14:0] == 15'h7FFF);
        logic fz = (m[62:0] == 63'h0);
        return {se[15], ez && fz, eo && fz, eo && !fz};
    endfunction

    function automatic logic ref_pred(input logic [3:0] c, input logic [3:0] f);
        logic n = f[3], z = f[2], u = f[0];
        case (c)
            4'h0: return 0;             4'h1: return z;
            4'h2: return !(u||z||n);    4'h3: return z || !(u||n);
            4'h4: return n && !(u||z);  4'h5: return z || (n && !u);
            4'h6: return !u && !z;      4'h7: return !u;
            4'h8: return u;             4'h9: return u || z;
            4'hA: return u || !(n||z);  4'hB: return u || z || !n;
            4'hC: return u || (n && !z); 4'hD: return u || z || n;
            4'hE: return !z;            default: return 1;
        endcase
    endfunction

    task automatic load_value(input logic [15:0] se, input logic [63:0] m, input string tag);
        logic [31:0] expst;
        @(negedge clk);
        upd_valid = 1'b1; upd_sign_exp = se; upd_mantissa = m;
        @(negedge clk);
        upd_valid = 1'b0;
        expst = (RST_VAL & 32'hF0FF_FFFF) | ({28'h0, ref_flags(se, m)} << 24);
        check(status_q == expst, tag, status_q, expst);
    endtask

    task automatic sweep_selectors(input logic [3:0] f);
        for (int s = 0; s < 64; s++) begin
            logic e;
            string tag;
            @(negedge clk);
            eval_req = 1'b1; eval_sel = 6'(s);
            @(negedge clk);
            eval_req = 1'b0;
            if (s >= 32) begin
                check(res_valid && illegal_sel && !cond_true && set_byte == 8'h00,
                      "R10 illegal selector", {res_valid, illegal_sel, cond_true, set_byte},
                      {3'b110, 8'h00});
            end else begin
                e = ref_pred(4'(s), f);
                tag = (s >= 16) ? "R6 bit4 ignored" : ((s % 16) < 8 ? "R7 predicate" : "R8 predicate");
                check(res_valid && !illegal_sel && cond_true == e, tag,
                      {s[7:0], res_valid, illegal_sel, cond_true}, {s[7:0], 2'b10, e});
                check(set_byte == {8{e}}, "R9 set byte", set_byte, {8{e}});
            end
        end
        @(negedge clk);
        check(!res_valid && !illegal_sel, "R11 no answer without request", res_valid, 0);
    endtask

    task automatic test_reset();
        check(status_q == RST_VAL, "R12 reset status", status_q, RST_VAL);
        check(!res_valid && !cond_true && !illegal_sel && set_byte == 0, "R12 reset outputs",
              {res_valid, cond_true, illegal_sel, set_byte}, 0);
    endtask

    task automatic test_class(input logic [15:0] se, input logic [63:0] m, input string tag);
        load_value(se, m, tag);
        sweep_selectors(ref_flags(se, m));
    endtask

    task automatic test_same_cycle();
        load_value(16'h0000, 64'h0, "R3 zero load");
        @(negedge clk);
        upd_valid = 1'b1; upd_sign_exp = 16'h7FFF; upd_mantissa = 64'h0;
        eval_req = 1'b1; eval_sel = 6'h01;
        @(negedge clk);
        upd_valid = 1'b0; eval_req = 1'b0;
        check(res_valid && cond_true, "R11 old flags used", cond_true, 1);
        check(status_q[27:24] == 4'b0010, "R4 infinity after collision", status_q[27:24], 4'b0010);
        @(negedge clk);
        check(!res_valid, "R11 single-cycle valid", res_valid, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_class(16'h3FFF, 64'h8000_0000_0000_0000, "R1 positive normal");
        test_class(16'hC000, 64'hC000_0000_0000_0000, "R2 negative normal");
        test_class(16'h0000, 64'h8000_0000_0000_0000, "R3 zero with bit63");
        test_class(16'h8000, 64'h0, "R2 negative zero");
        test_class(16'h7FFF, 64'h8000_0000_0000_0000, "R4 positive infinity");
        test_class(16'hFFFF, 64'h0, "R4 negative infinity");
        test_class(16'h7FFF, 64'h0000_0000_0000_0001, "R5 nan low bit");
        test_class(16'hFFFF, 64'hC000_0000_0000_0000, "R5 negative nan");
        test_class(16'h0000, 64'h0000_0000_0000_0010, "R3 denormal not zero");
        test_same_cycle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                checks++; errors++;
                $display("FAIL watchdog expired actual=0 expected=1");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule